// File: doc/BRIEF.md
# Wakeup Pin Controller with Retained Control Register

This block is an always-on power-control slice. It sits on an APB bus as a single 32-bit control register. For each of several external wakeup pins the register holds an enable bit and a bit that selects the active edge, rising or falling. It also holds two battery-charging controls, which only drive output pins. Register accesses are stretched with wait states, and a write takes longer than a read.

Each pin passes through a two-flop synchronizer. An edge detector compares the synchronized value with the value from the cycle before. When an enabled pin shows its selected edge, a sticky per-pin flag is set. The flags are OR-ed into a single wakeup request, and that request is raised only while the system reports a low-power state. Software or the sequencer clears flags with a write-one-to-clear strobe.

The control register survives the block-level reset used on standby exit and peripheral reset. Only the power-on reset clears it. For one cycle after every register write, edge detection is masked, so reprogramming an edge select cannot create a false wakeup.

Top module: `wkup_ctrl_top`

## Requirements
- R1: After power-on reset the register reads 0x00000000, and all flags, `wk_req`, `chg_en` and `chg_rsel` are 0.
- R2: The register is at byte offset 0x0C. Bits [5:0] are the pin enables (bit n for pin n). Bits [15:10] are the edge selects (bit 10+n for pin n). Bit 8 is the charge enable and bit 9 is the resistor select. All other bits read as 0, and writes to them are ignored, so writing 0xFFFFFFFF reads back 0x0000FF3F.
- R3: A write access holds `pready` low for exactly 3 access-phase cycles and completes in the 4th.
- R4: A read access holds `pready` low for exactly 2 access-phase cycles and completes in the 3rd.
- R5: `pslverr` is always 0. A read from any offset other than 0x0C returns 0, and a write there changes nothing.
- R6: `chg_en` follows register bit 8 (1 = charging on). `chg_rsel` follows bit 9 (0 = 5 kOhm, 1 = 1.5 kOhm).
- R7: With a pin enabled and its select at 0, a rising edge sets that pin's flag and a falling edge does not. The flag becomes visible after the third rising clock edge following the pin change.
- R8: With a pin enabled and its select at 1, a falling edge sets that pin's flag and a rising edge does not.
- R9: A pin whose enable bit is 0 never sets its flag.
- R10: `wk_req` is 1 exactly when `lp_active` is 1 and at least one flag is set.
- R11: A `flag_clr` pulse clears the flags at its set bit positions and leaves the other flags unchanged.
- R12: `blk_rst` clears all flags and the wait-state counter but leaves the control register unchanged. The register changes only on a completed write to 0x0C.
- R13: An edge that reaches the detector in the cycle right after a write completes is ignored. Later edges are detected normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low; clears everything |
| blk_rst | input | 1 | Synchronous block reset (standby exit / peripheral reset); register kept |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB direction, 1 = write |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, low during wait states |
| pslverr | output | 1 | APB error, always 0 |
| wk_pin | input | NUM_PINS | Asynchronous external wakeup pins |
| lp_active | input | 1 | System is in a low-power state |
| flag_clr | input | NUM_PINS | Write-one-to-clear strobe for the flags |
| wk_flag | output | NUM_PINS | Sticky per-pin wakeup flags |
| wk_req | output | 1 | Wakeup request |
| chg_en | output | 1 | Battery charging enable |
| chg_rsel | output | 1 | Charging resistor select |

## Verification
The bench drives inputs just after the falling clock edge and samples the outputs 1 ns after a falling edge, so every value it reads has settled since the previous rising edge. A pin change is counted in rising edges: two synchronizer stages and the compare register place a new flag after the third edge. The bench samples after two edges to confirm the flag is still clear, then after the third to see it set. `wk_req`, `prdata` and `pready` are combinational from state, so they are read in the same cycle as the stimulus that produces them. Wait states are counted as the access-phase cycles in which `pready` is sampled low. For the masking case, the pin is toggled in the last write wait cycle, which places its edge exactly in the masked cycle.

// File: rtl/wkup_pkg.sv
package wkup_pkg;
    // bit positions decoded by both the register and its checker
    parameter int unsigned SEL_LSB      = 10;
    parameter int unsigned CHG_EN_BIT   = 8;
    parameter int unsigned CHG_RSEL_BIT = 9;

    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_sel_e;
endpackage

// File: rtl/wkup_apb_if.sv
module wkup_apb_if #(
    parameter int unsigned ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 'h0C,
    parameter int unsigned WR_WAIT    = 3,
    parameter int unsigned RD_WAIT    = 2
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              blk_rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    output logic              pready,
    output logic              wr_done,
    output logic              rd_sel
);
    localparam int unsigned MAX_WAIT = (WR_WAIT > RD_WAIT) ? WR_WAIT : RD_WAIT;
    localparam int unsigned CNT_W    = (MAX_WAIT < 1) ? 1 : $clog2(MAX_WAIT + 1);
    localparam logic [CNT_W-1:0] WR_N = CNT_W'(WR_WAIT);
    localparam logic [CNT_W-1:0] RD_N = CNT_W'(RD_WAIT);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;
    logic access, hit, ready;

    always_comb begin
        st_d   = st_q;
        access = psel & penable;
        hit    = (paddr == REG_OFFSET);
        ready  = access && (st_q.cnt == (pwrite ? WR_N : RD_N));
        if (!access || ready) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        if (blk_rst) begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pready  = ready;
    assign wr_done = ready & pwrite & hit;
    assign rd_sel  = ready & ~pwrite & hit;
endmodule

// File: rtl/wkup_edge_det.sv
module wkup_edge_det #(
    parameter int unsigned NUM_PINS    = 6,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                por_n,
    input  logic [NUM_PINS-1:0] pin_i,
    input  logic [NUM_PINS-1:0] en_i,
    input  logic [NUM_PINS-1:0] sel_i,
    input  logic                mask_i,
    output logic [NUM_PINS-1:0] hit_o
);
    import wkup_pkg::*;

    typedef struct packed {
        logic [SYNC_STAGES-1:0][NUM_PINS-1:0] sync;
        logic [NUM_PINS-1:0]                  prev;
    } st_t;

    st_t st_d, st_q;
    logic [NUM_PINS-1:0] cur;

    always_comb begin
        st_d         = st_q;
        st_d.sync[0] = pin_i;
        for (int k = 1; k < SYNC_STAGES; k++) begin
            st_d.sync[k] = st_q.sync[k-1];
        end
        st_d.prev = st_q.sync[SYNC_STAGES-1];
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cur = st_q.sync[SYNC_STAGES-1];

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        logic rise, fall;
        assign rise     = cur[g] & ~st_q.prev[g];
        assign fall     = ~cur[g] & st_q.prev[g];
        assign hit_o[g] = en_i[g] & ~mask_i &
                          ((edge_sel_e'(sel_i[g]) == EDGE_FALL) ? fall : rise);
    end
endmodule

// File: rtl/wkup_ctrl_top.sv
module wkup_ctrl_top #(
    parameter int unsigned NUM_PINS    = 6,
    parameter int unsigned ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 'h0C,
    parameter int unsigned WR_WAIT     = 3,
    parameter int unsigned RD_WAIT     = 2,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                por_n,
    input  logic                blk_rst,
    input  logic                psel,
    input  logic                penable,
    input  logic                pwrite,
    input  logic [ADDR_W-1:0]   paddr,
    input  logic [31:0]         pwdata,
    output logic [31:0]         prdata,
    output logic                pready,
    output logic                pslverr,
    input  logic [NUM_PINS-1:0] wk_pin,
    input  logic                lp_active,
    input  logic [NUM_PINS-1:0] flag_clr,
    output logic [NUM_PINS-1:0] wk_flag,
    output logic                wk_req,
    output logic                chg_en,
    output logic                chg_rsel
);
    import wkup_pkg::*;

    typedef struct packed {
        logic [NUM_PINS-1:0] en;
        logic [NUM_PINS-1:0] sel;
        logic                chg_en;
        logic                chg_rsel;
        logic [NUM_PINS-1:0] flag;
        logic                mask;
    } st_t;

    st_t st_d, st_q;
    logic                wr_done, rd_sel;
    logic [NUM_PINS-1:0] edge_hit;
    logic [31:0]         ctrl_word;

    wkup_apb_if #(
        .ADDR_W     (ADDR_W),
        .REG_OFFSET (REG_OFFSET),
        .WR_WAIT    (WR_WAIT),
        .RD_WAIT    (RD_WAIT)
    ) u_apb (
        .clk     (clk),
        .por_n   (por_n),
        .blk_rst (blk_rst),
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .pready  (pready),
        .wr_done (wr_done),
        .rd_sel  (rd_sel)
    );

    wkup_edge_det #(
        .NUM_PINS    (NUM_PINS),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_edge (
        .clk    (clk),
        .por_n  (por_n),
        .pin_i  (wk_pin),
        .en_i   (st_q.en),
        .sel_i  (st_q.sel),
        .mask_i (st_q.mask),
        .hit_o  (edge_hit)
    );

    always_comb begin
        ctrl_word                         = '0;
        ctrl_word[NUM_PINS-1:0]           = st_q.en;
        ctrl_word[SEL_LSB +: NUM_PINS]    = st_q.sel;
        ctrl_word[CHG_EN_BIT]             = st_q.chg_en;
        ctrl_word[CHG_RSEL_BIT]           = st_q.chg_rsel;
    end

    always_comb begin
        st_d      = st_q;
        st_d.mask = wr_done;
        if (wr_done) begin
            st_d.en       = pwdata[NUM_PINS-1:0];
            st_d.sel      = pwdata[SEL_LSB +: NUM_PINS];
            st_d.chg_en   = pwdata[CHG_EN_BIT];
            st_d.chg_rsel = pwdata[CHG_RSEL_BIT];
        end
        st_d.flag = (st_q.flag & ~flag_clr) | edge_hit;
        if (blk_rst) begin
            st_d.flag = '0;
            st_d.mask = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign prdata   = rd_sel ? ctrl_word : 32'h0;
    assign pslverr  = 1'b0;
    assign wk_flag  = st_q.flag;
    assign wk_req   = lp_active & (|st_q.flag);
    assign chg_en   = st_q.chg_en;
    assign chg_rsel = st_q.chg_rsel;
endmodule

// File: rtl/wkup_ctrl_chk.sv
module wkup_ctrl_chk #(
    parameter int unsigned NUM_PINS = 6,
    parameter int unsigned WR_WAIT  = 3,
    parameter int unsigned RD_WAIT  = 2
) (
    input logic                clk,
    input logic                por_n,
    input logic                psel,
    input logic                penable,
    input logic                pwrite,
    input logic                pready,
    input logic [31:0]         prdata,
    input logic                lp_active,
    input logic                wk_req,
    input logic [NUM_PINS-1:0] wk_flag,
    input logic [NUM_PINS-1:0] pin_en,
    input logic [31:0]         ctrl_word,
    input logic                wr_done
);
    import wkup_pkg::*;

    localparam logic [31:0] PIN_ONES = (32'd1 << NUM_PINS) - 32'd1;
    localparam logic [31:0] RW_MASK  = PIN_ONES | (PIN_ONES << SEL_LSB) |
                                       (32'd1 << CHG_EN_BIT) | (32'd1 << CHG_RSEL_BIT);

    logic [7:0] wcnt;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            wcnt <= '0;
        end else if (psel && penable && !pready) begin
            wcnt <= wcnt + 8'd1;
        end else begin
            wcnt <= '0;
        end
    end

    AST_WR_WAIT_COUNT: assert property (@(posedge clk) disable iff (!por_n)
        (psel && penable && pready && pwrite) |-> (wcnt == 8'(WR_WAIT))); // R3
    AST_RD_WAIT_COUNT: assert property (@(posedge clk) disable iff (!por_n)
        (psel && penable && pready && !pwrite) |-> (wcnt == 8'(RD_WAIT))); // R4
    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!por_n)
        (psel && penable && pready && !pwrite) |-> ((prdata & ~RW_MASK) == 32'h0)); // R2
    AST_FLAG_NEEDS_EN: assert property (@(posedge clk) disable iff (!por_n)
        1'b1 |=> ((wk_flag & ~$past(wk_flag) & ~$past(pin_en)) == '0)); // R9
    AST_REQ_GATED: assert property (@(posedge clk) disable iff (!por_n)
        wk_req == (lp_active && (|wk_flag))); // R10
    AST_REG_HOLD: assert property (@(posedge clk) disable iff (!por_n)
        !wr_done |=> $stable(ctrl_word)); // R12
    AST_MASK_AFTER_WRITE: assert property (@(posedge clk) disable iff (!por_n)
        wr_done |=> ##1 ((wk_flag & ~$past(wk_flag)) == '0)); // R13
endmodule

bind wkup_ctrl_top wkup_ctrl_chk #(
    .NUM_PINS (NUM_PINS),
    .WR_WAIT  (WR_WAIT),
    .RD_WAIT  (RD_WAIT)
) u_chk (
    .clk       (clk),
    .por_n     (por_n),
    .psel      (psel),
    .penable   (penable),
    .pwrite    (pwrite),
    .pready    (pready),
    .prdata    (prdata),
    .lp_active (lp_active),
    .wk_req    (wk_req),
    .wk_flag   (wk_flag),
    .pin_en    (st_q.en),
    .ctrl_word (ctrl_word),
    .wr_done   (wr_done)
);

// File: tb/tb_wkup_ctrl_top.sv
`timescale 1ns/1ps
module tb_wkup_ctrl_top;
    localparam int NP = 6;

    logic          clk = 1'b0;
    logic          por_n = 1'b0;
    logic          blk_rst = 1'b0;
    logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]    paddr = '0;
    logic [31:0]   pwdata = '0;
    logic [31:0]   prdata;
    logic          pready, pslverr;
    logic [NP-1:0] wk_pin = '0;
    logic          lp_active = 1'b0;
    logic [NP-1:0] flag_clr = '0;
    logic [NP-1:0] wk_flag;
    logic          wk_req, chg_en, chg_rsel;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        string       tag;
        logic [31:0] val;
    } item_t;
    item_t exp_q[$];
    item_t act_q[$];

    always #2.5 clk = ~clk;

    wkup_ctrl_top dut (
        .clk(clk), .por_n(por_n), .blk_rst(blk_rst),
        .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
        .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr),
        .wk_pin(wk_pin), .lp_active(lp_active), .flag_clr(flag_clr),
        .wk_flag(wk_flag), .wk_req(wk_req), .chg_en(chg_en), .chg_rsel(chg_rsel)
    );

    // monitor: pops expected/actual pairs and compares
    always @(negedge clk) begin
        while (exp_q.size() > 0 && act_q.size() > 0) begin
            item_t e, a;
            e = exp_q.pop_front();
            a = act_q.pop_front();
            checks++;
            if (e.val !== a.val) begin
                fails++;
                $display("FAIL %s actual=%h expected=%h", e.tag, a.val, e.val);
            end
        end
    end

    task automatic expect_val(input string tag, input logic [31:0] exp, input logic [31:0] act);
        exp_q.push_back('{tag, exp});
        act_q.push_back('{tag, act});
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic apb_write(input logic [7:0] a, input logic [31:0] d,
                             input int tog_at, input logic [NP-1:0] tog,
                             output int waits);
        waits = 0;
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        #1;
        while (!pready) begin
            if (waits == tog_at) wk_pin = wk_pin ^ tog;
            waits++;
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
        #1;
    endtask

    task automatic apb_read(input logic [7:0] a, output logic [31:0] d, output int waits);
        waits = 0;
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
        @(negedge clk);
        penable = 1'b1;
        #1;
        while (!pready) begin
            waits++;
            @(negedge clk);
            #1;
        end
        d = prdata;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
        #1;
    endtask

    task automatic pulse_clr(input logic [NP-1:0] m);
        @(negedge clk);
        flag_clr = m;
        @(negedge clk);
        flag_clr = '0;
        #1;
    endtask

    task automatic check_flags(input string tag, input logic [NP-1:0] exp);
        expect_val(tag, 32'(exp), 32'(wk_flag));
    endtask

    // watchdog
    initial begin
        #200000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        int w;
        cyc(3);
        por_n = 1'b1;
        cyc(2);

        // R1 reset state
        expect_val("R1 outputs", 32'h0, {27'h0, chg_en, chg_rsel, wk_req, |wk_flag, pslverr});
        apb_read(8'h0C, rd, w);
        expect_val("R1 reg", 32'h0, rd);
        expect_val("R4 read waits", 32'd2, 32'(w));

        // R2/R3 write all ones, reserved bits dropped
        apb_write(8'h0C, 32'hFFFF_FFFF, -1, '0, w);
        expect_val("R3 write waits", 32'd3, 32'(w));
        apb_read(8'h0C, rd, w);
        expect_val("R2 readback", 32'h0000_FF3F, rd);
        expect_val("R6 chg both", 32'h3, {30'h0, chg_rsel, chg_en});

        // R6 charge enable only, resistor 5k
        apb_write(8'h0C, 32'h0000_0100, -1, '0, w);
        expect_val("R6 chg en only", 32'h1, {30'h0, chg_rsel, chg_en});

        // R5 unmapped offset
        apb_write(8'h10, 32'hFFFF_FFFF, -1, '0, w);
        apb_read(8'h0C, rd, w);
        expect_val("R5 unmapped write ignored", 32'h0000_0100, rd);
        apb_read(8'h10, rd, w);
        expect_val("R5 unmapped read zero", 32'h0, rd);
        expect_val("R5 pslverr", 32'h0, {31'h0, pslverr});

        // enable pins 0..4, pins 3,4 falling, pin 5 disabled
        apb_write(8'h0C, 32'h0000_601F, -1, '0, w);
        cyc(3);

        // R7 rising edge on pin 0, latency 3 edges
        @(negedge clk); wk_pin[0] = 1'b1;
        cyc(2);
        check_flags("R7 not yet", 6'b000000);
        cyc(1);
        check_flags("R7 rise pin0", 6'b000001);

        // R8 pin 3 falling-selected: rise ignored, fall sets
        @(negedge clk); wk_pin[3] = 1'b1;
        cyc(5);
        check_flags("R8 rise ignored", 6'b000001);
        @(negedge clk); wk_pin[3] = 1'b0;
        cyc(5);
        check_flags("R8 fall pin3", 6'b001001);

        // R7 pin 1 rise sets, fall ignored
        @(negedge clk); wk_pin[1] = 1'b1;
        cyc(5);
        @(negedge clk); wk_pin[1] = 1'b0;
        cyc(5);
        check_flags("R7 pin1 rise only", 6'b001011);

        // R9 disabled pin 5
        @(negedge clk); wk_pin[5] = 1'b1;
        cyc(5);
        @(negedge clk); wk_pin[5] = 1'b0;
        cyc(5);
        check_flags("R9 disabled pin", 6'b001011);

        // R10 request gating
        expect_val("R10 req lp low", 32'h0, {31'h0, wk_req});
        @(negedge clk); lp_active = 1'b1; #1;
        expect_val("R10 req lp high", 32'h1, {31'h0, wk_req});

        // R11 write-one-to-clear
        pulse_clr(6'b000011);
        check_flags("R11 partial clear", 6'b001000);
        expect_val("R10 req still set", 32'h1, {31'h0, wk_req});
        pulse_clr(6'b001000);
        check_flags("R11 full clear", 6'b000000);
        expect_val("R10 req no flags", 32'h0, {31'h0, wk_req});

        // R12 block reset clears flags, keeps register
        @(negedge clk); wk_pin[0] = 1'b0;
        cyc(5);
        @(negedge clk); wk_pin[0] = 1'b1;
        cyc(5);
        check_flags("R12 flag before", 6'b000001);
        @(negedge clk); blk_rst = 1'b1;
        @(negedge clk); blk_rst = 1'b0;
        cyc(3);
        check_flags("R12 flags cleared", 6'b000000);
        apb_read(8'h0C, rd, w);
        expect_val("R12 reg kept", 32'h0000_601F, rd);

        // R13 edge landing in the cycle after a write is masked
        apb_write(8'h0C, 32'h0000_601F, 2, 6'b000100, w);
        cyc(5);
        check_flags("R13 masked edge", 6'b000000);
        @(negedge clk); wk_pin[2] = 1'b0;
        cyc(5);
        @(negedge clk); wk_pin[2] = 1'b1;
        cyc(5);
        check_flags("R13 later edge", 6'b000100);

        cyc(3);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule